// File: doc/BRIEF.md
# Shared-Pin Status LED Refresh Controller

This block drives four status LEDs (a green and a yellow LED for each of two channels) over pins that are also used by a flash SPI interface. It does not hold the pins all the time. Instead it claims them in short refresh cycles of fixed length, which start on a fixed interval. During each cycle it drives the LED levels onto the pins. At the end of each cycle it polls a push button on the same pin group. Outside a cycle every pin is released: its output enable is low and its data output is low.

Each LED has a 2-bit mode: off, steady on, slow blink or fast blink. A free-running prescaler supplies the blink timing. Its top bit sets the slow rate, and the bit two places below it toggles four times as fast. All LEDs therefore blink in a common phase.

A single control/status register holds the four modes and a run bit. It also reports whether a refresh cycle is active and the last button level sampled. Before it uses the flash, software clears the run bit and waits for the active flag to fall. The cycle in progress always completes before the flag drops.

Top module: `led_refresh_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, all LED modes are off, run is 0, the active flag is 0, the button status is 0, and `led_oe` and `led_o` are all 0.
- R2: `reg_rdata` reports the register fields as follows:
  - bits [7:0]: the four LED modes, LED i in bits [2i+1:2i].
  - bit 8: the run bit.
  - bit 9: the active flag.
  - bit 10: the button status.
  - bits [31:11]: always 0.
  
  A write with `reg_we` high loads bits [8:0] of `reg_wdata` at that clock edge.
- R3: The LED order is: 0 for channel 0 green, 1 for channel 0 yellow, 2 for channel 1 green, 3 for channel 1 yellow. During a refresh cycle, pin `led_o[i]` follows the mode of LED i:
  - 00: drives 0.
  - 01: drives 1.
  - 10: drives prescaler bit PRESC_W-1 (slow blink).
  - 11: drives prescaler bit PRESC_W-3 (fast blink, four times the slow rate).
  
  The prescaler counts clock edges since reset.
- R4: An interval counter wraps every IVL clocks. A refresh cycle starts only on the edge where this counter wraps, and only if run was 1 before that edge. The first possible start is IVL edges after reset.
- R5: Once started, a refresh cycle lasts exactly CYC clocks, and the active flag is 1 for exactly those clocks.
- R6: Clearing run while a cycle is in progress does not shorten that cycle. It only prevents later cycles from starting.
- R7: During a refresh cycle all four `led_oe` bits are 1. Otherwise all four are 0, and `led_o` is 0.
- R8: On the edge that ends a refresh cycle, the button level `btn_i` is captured into the button status. The status holds that value until the next cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value (modes, run, active, button) |
| btn_i | input | 1 | Push button level from the shared pin |
| led_o | output | 4 | LED drive levels for the shared pins |
| led_oe | output | 4 | Output enables for the shared pins |

## Verification
The assertions check the following on every cycle:
- The enables are either all 0 or all 1.
- The pins are dark and released whenever no cycle is active.
- No cycle starts without run.
- An active cycle never ends early and never runs longer than CYC clocks.
- The button status changes only as a cycle ends.

Only the bench's scenarios can show the remaining behaviour:
- The exact start edges relative to the interval counter.
- The blink waveforms for each mode.
- The decoding of the mode fields.
- That a run bit cleared in mid-cycle leaves that cycle intact but suppresses the next one.

// File: rtl/led_refresh_ctrl.sv
module led_refresh_ctrl #(
  parameter int PRESC_W = 8,
  parameter int IVL     = 32,
  parameter int CYC     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        btn_i,
  output logic [3:0]  led_o,
  output logic [3:0]  led_oe
);
  localparam int IW = $clog2(IVL);
  localparam int CW = $clog2(CYC + 1);

  logic [7:0]         modes;
  logic               run, active, btn_q;
  logic [PRESC_W-1:0] presc;
  logic [IW-1:0]      ivl;
  logic [CW-1:0]      ph;

  wire tick = (ivl == IW'(IVL - 1));
  wire slow = presc[PRESC_W-1];
  wire fast = presc[PRESC_W-3];

  always_ff @(posedge clk) begin
    if (rst) begin
      modes  <= '0;
      run    <= 1'b0;
      active <= 1'b0;
      btn_q  <= 1'b0;
      presc  <= '0;
      ivl    <= '0;
      ph     <= '0;
    end else begin
      presc <= presc + 1'b1;
      ivl   <= tick ? '0 : ivl + 1'b1;
      if (reg_we) {run, modes} <= reg_wdata[8:0];
      if (active) begin
        ph <= ph + 1'b1;
        if (ph == CW'(CYC - 1)) begin
          active <= 1'b0;
          btn_q  <= btn_i;
        end
      end else if (tick && run) begin
        active <= 1'b1;
        ph     <= '0;
      end
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_led
    logic lvl;
    always_comb begin
      case (modes[2*i +: 2])
        2'b00:   lvl = 1'b0;
        2'b01:   lvl = 1'b1;
        2'b10:   lvl = slow;
        default: lvl = fast;
      endcase
    end
    assign led_o[i]  = active & lvl;
    assign led_oe[i] = active;
  end

  assign reg_rdata = {21'b0, btn_q, active, run, modes};
endmodule

// File: rtl/led_refresh_ctrl_chk.sv
module led_refresh_ctrl_chk #(
  parameter int CYC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] reg_rdata,
  input logic [3:0]  led_o,
  input logic [3:0]  led_oe
);
  wire act = reg_rdata[9];
  logic [15:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !act) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  p_oe_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    (led_oe == 4'h0) || (led_oe == 4'hF));
  p_dark_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !act |-> (led_oe == 4'h0 && led_o == 4'h0));
  p_start_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> $past(reg_rdata[8]));
  p_no_early_end_r6: assert property (@(posedge clk) disable iff (rst)
    (act && cnt < 16'(CYC - 1)) |=> act);
  p_len_max_r5: assert property (@(posedge clk) disable iff (rst)
    act |-> cnt < 16'(CYC));
  p_btn_on_end_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_rdata[10]) |-> $fell(act));
endmodule

bind led_refresh_ctrl led_refresh_ctrl_chk #(.CYC(CYC)) u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .led_o(led_o), .led_oe(led_oe)
);

// File: tb/led_refresh_ctrl_bench.sv
module led_refresh_ctrl_bench;
  localparam int PW  = 8;
  localparam int IVL = 32;
  localparam int CYC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        btn_i = 1'b0;
  logic [3:0]  led_o, led_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  led_refresh_ctrl #(.PRESC_W(PW), .IVL(IVL), .CYC(CYC)) u_led_refresh_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .btn_i(btn_i), .led_o(led_o), .led_oe(led_oe)
  );

  // Expected state from the requirements
  int       m;
  logic [7:0] modes_s;
  logic     run_s, cyc_on, btn_exp;

  always @(posedge clk) begin
    if (rst) begin
      m <= 0; modes_s <= '0; run_s <= 1'b0; cyc_on <= 1'b0; btn_exp <= 1'b0;
    end else begin
      m <= m + 1;
      if (reg_we) {run_s, modes_s} <= reg_wdata[8:0];
      if ((m + 1) % IVL == 0) cyc_on <= run_s;
      if ((m + 1) % IVL == CYC && cyc_on) btn_exp <= btn_i;
    end
  end

  function automatic logic exp_active(int mm, logic on);
    return on && (mm % IVL) < CYC;
  endfunction

  function automatic logic exp_pin(logic [1:0] md, int mm);
    case (md)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return 1'((mm >> (PW - 1)) & 1);
      default: return 1'((mm >> (PW - 3)) & 1);
    endcase
  endfunction

  function automatic logic [3:0] exp_leds(logic [7:0] md, int mm, logic on);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = exp_active(mm, on) & exp_pin(md[2*i +: 2], mm);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at m=%0d", tag, act, exp, m);
    end
  endtask

  logic prev_exp_act = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      logic ea;
      ea = exp_active(m, cyc_on);
      chk("R7 oe", 32'(led_oe), ea ? 32'hF : 32'h0);
      chk("R3 led_o", 32'(led_o), 32'(exp_leds(modes_s, m, cyc_on)));
      chk("R5 active", 32'(reg_rdata[9]), 32'(ea));
      chk("R8 button", 32'(reg_rdata[10]), 32'(btn_exp));
      chk("R2 fields", {reg_rdata[31:11], reg_rdata[8:0]}, {21'b0, run_s, modes_s});
      if (ea && !prev_exp_act) chk("R4 start edge", 32'(m % IVL), 32'd0);
      prev_exp_act = ea;
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 oe", 32'(led_oe), 32'h0);
    chk("R1 led_o", 32'(led_o), 32'h0);

    // R3: all four modes at once, R4 first start
    wr(32'h1E4);
    repeat (600) @(negedge clk);

    // R6: clear run inside a cycle
    while (reg_rdata[9] !== 1'b1) @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = 32'h0E4;
    @(negedge clk); reg_we = 1'b0;
    #1 chk("R6 active kept", 32'(reg_rdata[9]), 32'd1);
    repeat (2 * IVL) @(negedge clk);
    #1 chk("R6 no new cycle", 32'(reg_rdata[9]), 32'd0);

    // R8: button toggles while running
    wr(32'h1FF);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); btn_i = k[3];
    end

    // random mix
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      btn_i = 1'($urandom % 2);
      if ($urandom % 40 == 0) begin
        reg_we = 1'b1;
        reg_wdata = $urandom;
        reg_wdata[8] = ($urandom % 4) != 0;
      end else reg_we = 1'b0;
    end
    @(negedge clk); reg_we = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule